// File: doc/BRIEF.md
# Receive Buffer Readout Formatter

This block sits on the read side of a packet receive path. Packet bytes are held in an internal word queue (32-bit words, little-endian byte packing), and each packet's byte length is held in a small companion length queue. A host pulls the packet out one 32-bit word per read strobe. On the way out the block inserts a programmable number of zero bytes ahead of the first packet byte and appends zero words after the last one, so that the number of words read for that packet fills a chosen alignment.

A word countdown, loaded by software, drops by one for every word the host reads, filler included. When it reaches zero it raises a sticky interrupt flag. A discard command empties both queues in one step and abandons any packet being read. The discard indication clears itself on the next cycle.

Top module: `rx_readout_fmt`

## Requirements
- R1: Each packet is read as a byte stream made of `cfg_offset` (0 to 31) zero bytes followed by the packet bytes. Stream byte s appears in read word s/4, lane s%4, at bits 8*(s%4)+7 down to 8*(s%4).
- R2: After the last word that holds a packet byte, zero words are appended until the packet's word count is a multiple of N. The alignment code `cfg_end_align` sets N: 0 gives 1 word (4 bytes), 1 gives 4 words (16 bytes), 2 gives 8 words (32 bytes), and 3 is treated as code 0. `rd_last` is 1 on the final word of a packet and 0 on every other word.
- R3: The alignment code is captured at a packet's first read. Changing it while the packet is partly read does not change that packet's length.
- R4: The word part of the offset (`cfg_offset[4:2]`) is compared on every read during the leading zero words, so a change takes effect on the next read. The byte part (`cfg_offset[1:0]`) is captured at the packet's first read.
- R5: A packet with byte length L takes ceil(L/4) queue words and starts at byte 0 of a fresh word. Packet byte i sits in queue word i/4, lane i%4. Queue bytes past L read out as zero.
- R6: A strobe is accepted when a packet is in progress or a length entry is waiting. The word then appears on `rd_data` with `rd_valid` high in the cycle after the strobe edge. A strobe that is not accepted changes no output and no queue.
- R7: A `cnt_load` pulse replaces the countdown with `cnt_value`, including while it is running. Each accepted read lowers the countdown by one. It stops at zero, and a load wins over a read in the same cycle.
- R8: `irq` sets when a read takes the countdown from 1 to 0 and stays set until an `irq_clr` pulse. A set in the same cycle wins over the clear.
- R9: A `discard_req` pulse raises `discard_busy` for exactly one cycle. In that cycle both queues are emptied and any partly read packet is dropped. Pushes made in that cycle are lost, and after it both levels and `pkt_avail` are 0.
- R10: The writer pushes a packet's data words before its length entry, and lengths run from 1 up. `pkt_avail` is 1 exactly when at least one length entry is waiting that no read has started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data_valid | input | 1 | Push `wr_data` into the word queue |
| wr_data | input | 32 | Packed packet bytes |
| wr_len_valid | input | 1 | Push `wr_len` into the length queue |
| wr_len | input | LEN_W | Packet byte length |
| cfg_end_align | input | 2 | Alignment code |
| cfg_offset | input | 5 | Leading zero bytes |
| cnt_load | input | 1 | Load the countdown |
| cnt_value | input | CNT_W | Countdown load value |
| irq_clr | input | 1 | Clear the interrupt flag |
| discard_req | input | 1 | Discard all queued data |
| rd_strobe | input | 1 | Host read request |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | `rd_data` holds a new word |
| rd_last | output | 1 | Final word of the packet |
| pkt_avail | output | 1 | A length entry is waiting |
| irq | output | 1 | Countdown interrupt flag |
| cnt_remaining | output | CNT_W | Current countdown value |
| discard_busy | output | 1 | Discard in progress |
| data_level | output | DLW | Words in the word queue |
| stat_level | output | SLW | Entries in the length queue |

## Verification
Some rules are checked on every cycle. A valid word only follows a strobe. The countdown either drops by one per read or holds at zero. The interrupt only rises at zero and stays set until cleared. A discard lasts a single cycle and leaves both queues empty. Byte placement, zero masking, padding counts and the position of `rd_last` can only be shown by the scenarios, which sweep every offset and alignment code over a range of lengths. The same holds for the capture rules on alignment and byte offset.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [1:0] {
        PH_LEAD = 2'd0,
        PH_DATA = 2'd1,
        PH_PAD  = 2'd2
    } rxf_phase_e;

    // Low bits of the emitted-word count that must be zero at packet end.
    function automatic logic [2:0] align_mask(input logic [1:0] code);
        case (code)
            2'b01:   return 3'b011;
            2'b10:   return 3'b111;
            default: return 3'b000;
        endcase
    endfunction
endpackage

// File: rtl/rxf_fifo.sv
module rxf_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] lvl;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign push_ok = push && !flush && (st_q.lvl != LW'(DEPTH));
    assign pop_ok  = pop && !flush && (st_q.lvl != '0);

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wp = st_q.wp + AW'(1);
            if (pop_ok)  st_d.rp = st_q.rp + AW'(1);
            st_d.lvl = st_q.lvl + LW'(push_ok) - LW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wp] <= din;
    end

    assign dout  = mem[st_q.rp];
    assign level = st_q.lvl;
    assign empty = (st_q.lvl == '0);
endmodule

// File: rtl/rxf_countdown.sv
module rxf_countdown #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    input  logic          irq_clr,
    output logic [CW-1:0] count,
    output logic          irq
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } cd_st_t;

    cd_st_t st_d, st_q;
    logic hit_zero;

    assign hit_zero = !load && dec && (st_q.cnt == CW'(1));

    always_comb begin
        st_d = st_q;
        if (load)                       st_d.cnt = load_val;
        else if (dec && st_q.cnt != '0) st_d.cnt = st_q.cnt - CW'(1);
        if (irq_clr)  st_d.flag = 1'b0;
        if (hit_zero) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign irq   = st_q.flag;
endmodule

// File: rtl/rxf_lane_align.sv
module rxf_lane_align #(
    parameter int LEN_W = 11
) (
    input  logic [31:0]      cur,
    input  logic [31:0]      prev,
    input  logic [1:0]       boff,
    input  logic [LEN_W-1:0] word_idx,
    input  logic [LEN_W-1:0] len,
    output logic [31:0]      dout
);
    localparam int LANES = 4;
    localparam int PW    = LEN_W + 2;

    logic [63:0] cat;
    logic [5:0]  sh_amt;
    logic [31:0] shifted;
    logic [PW-1:0] lo, hi;

    assign cat     = {cur, prev};
    assign sh_amt  = 6'd32 - {1'b0, boff, 3'b000};
    assign shifted = 32'(cat >> sh_amt);
    assign lo      = PW'(boff);
    assign hi      = PW'(len) + PW'(boff);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [PW-1:0] pos;
        logic          keep;
        assign pos  = {word_idx, 2'(j)};
        assign keep = (pos >= lo) && (pos < hi);
        assign dout[8*j +: 8] = keep ? shifted[8*j +: 8] : 8'h00;
    end
endmodule

// File: rtl/rx_readout_fmt.sv
module rx_readout_fmt
    import rxf_pkg::*;
#(
    parameter int DATA_DEPTH = 16,
    parameter int STAT_DEPTH = 4,
    parameter int LEN_W      = 11,
    parameter int CNT_W      = 12,
    localparam int DLW       = $clog2(DATA_DEPTH + 1),
    localparam int SLW       = $clog2(STAT_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data_valid,
    input  logic [31:0]      wr_data,
    input  logic             wr_len_valid,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [1:0]       cfg_end_align,
    input  logic [4:0]       cfg_offset,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic             irq_clr,
    input  logic             discard_req,
    input  logic             rd_strobe,
    output logic [31:0]      rd_data,
    output logic             rd_valid,
    output logic             rd_last,
    output logic             pkt_avail,
    output logic             irq,
    output logic [CNT_W-1:0] cnt_remaining,
    output logic             discard_busy,
    output logic [DLW-1:0]   data_level,
    output logic [SLW-1:0]   stat_level
);
    localparam int XW = LEN_W + 1;

    typedef struct packed {
        logic             in_pkt;
        rxf_phase_e       phase;
        logic [2:0]       lead;
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] len;
        logic [1:0]       boff;
        logic [2:0]       amask;
        logic [2:0]       emit;
        logic [31:0]      carry;
        logic [31:0]      rdata;
        logic             rvalid;
        logic             rlast;
        logic             discard;
    } rd_st_t;

    rd_st_t st_d, st_q;

    logic [31:0]      data_dout;
    logic             data_empty, stat_empty;
    logic [LEN_W-1:0] stat_dout;
    logic             accept, starting, data_pop, stat_pop;

    // Effective packet context: fresh values on the first read, held ones after.
    rxf_phase_e       e_phase;
    logic [LEN_W-1:0] e_len, e_idx;
    logic [1:0]       e_boff;
    logic [2:0]       e_amask, e_lead, e_emit, emit_n;
    logic [31:0]      e_carry, cur_word, shaped;
    logic [XW-1:0]    d_words, f_words;
    logic             in_lead, in_pad, has_src, data_end, aligned;

    assign accept   = rd_strobe && !st_q.discard && (st_q.in_pkt || !stat_empty);
    assign starting = !st_q.in_pkt;

    assign e_phase = starting ? PH_LEAD : st_q.phase;
    assign e_len   = starting ? stat_dout : st_q.len;
    assign e_idx   = starting ? '0 : st_q.idx;
    assign e_boff  = starting ? cfg_offset[1:0] : st_q.boff;
    assign e_amask = starting ? align_mask(cfg_end_align) : st_q.amask;
    assign e_lead  = starting ? 3'd0 : st_q.lead;
    assign e_emit  = starting ? 3'd0 : st_q.emit;
    assign e_carry = starting ? 32'd0 : st_q.carry;

    assign d_words  = ({1'b0, e_len} + XW'(e_boff) + XW'(3)) >> 2;
    assign f_words  = ({1'b0, e_len} + XW'(3)) >> 2;
    assign in_lead  = (e_phase == PH_LEAD) && (e_lead < cfg_offset[4:2]);
    assign in_pad   = (e_phase == PH_PAD);
    assign has_src  = ({1'b0, e_idx} < f_words);
    assign data_end = (({1'b0, e_idx} + XW'(1)) == d_words);
    assign emit_n   = e_emit + 3'd1;
    assign aligned  = ((emit_n & e_amask) == 3'd0);
    assign cur_word = has_src ? data_dout : 32'd0;

    assign data_pop = accept && !in_lead && !in_pad && has_src;
    assign stat_pop = accept && starting;

    rxf_lane_align #(.LEN_W(LEN_W)) u_align (
        .cur      (cur_word),
        .prev     (e_carry),
        .boff     (e_boff),
        .word_idx (e_idx),
        .len      (e_len),
        .dout     (shaped)
    );

    rxf_fifo #(.W(32), .DEPTH(DATA_DEPTH)) u_data_q (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (st_q.discard),
        .push  (wr_data_valid),
        .din   (wr_data),
        .pop   (data_pop),
        .dout  (data_dout),
        .level (data_level),
        .empty (data_empty)
    );

    rxf_fifo #(.W(LEN_W), .DEPTH(STAT_DEPTH)) u_stat_q (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (st_q.discard),
        .push  (wr_len_valid),
        .din   (wr_len),
        .pop   (stat_pop),
        .dout  (stat_dout),
        .level (stat_level),
        .empty (stat_empty)
    );

    rxf_countdown #(.CW(CNT_W)) u_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_value),
        .dec      (accept),
        .irq_clr  (irq_clr),
        .count    (cnt_remaining),
        .irq      (irq)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rvalid  = 1'b0;
        st_d.rlast   = 1'b0;
        st_d.discard = discard_req && !st_q.discard;
        if (st_q.discard) begin
            st_d.in_pkt = 1'b0;
            st_d.phase  = PH_LEAD;
        end else if (accept) begin
            st_d.rvalid = 1'b1;
            st_d.in_pkt = 1'b1;
            st_d.len    = e_len;
            st_d.boff   = e_boff;
            st_d.amask  = e_amask;
            st_d.emit   = emit_n;
            st_d.idx    = e_idx;
            st_d.carry  = e_carry;
            st_d.lead   = e_lead;
            if (in_lead) begin
                st_d.rdata = 32'd0;
                st_d.phase = PH_LEAD;
                st_d.lead  = e_lead + 3'd1;
            end else if (!in_pad) begin
                st_d.rdata = shaped;
                st_d.carry = cur_word;
                st_d.idx   = e_idx + LEN_W'(1);
                st_d.phase = PH_DATA;
                if (data_end) begin
                    if (aligned) begin
                        st_d.in_pkt = 1'b0;
                        st_d.rlast  = 1'b1;
                    end else begin
                        st_d.phase  = PH_PAD;
                    end
                end
            end else begin
                st_d.rdata = 32'd0;
                if (aligned) begin
                    st_d.in_pkt = 1'b0;
                    st_d.rlast  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data      = st_q.rdata;
    assign rd_valid     = st_q.rvalid;
    assign rd_last      = st_q.rlast;
    assign pkt_avail    = !stat_empty;
    assign discard_busy = st_q.discard;

    logic unused_ok;
    assign unused_ok = data_empty;
endmodule

// File: rtl/rx_readout_fmt_chk.sv
module rx_readout_fmt_chk #(
    parameter int CNT_W = 12,
    parameter int DLW   = 5,
    parameter int SLW   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_strobe,
    input logic             rd_valid,
    input logic             discard_busy,
    input logic [DLW-1:0]   data_level,
    input logic [SLW-1:0]   stat_level,
    input logic             pkt_avail,
    input logic             irq,
    input logic             irq_clr,
    input logic             cnt_load,
    input logic [CNT_W-1:0] cnt_remaining
);
    // R6
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_strobe));

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !$past(cnt_load) && $past(cnt_remaining) != '0)
        |-> cnt_remaining == $past(cnt_remaining) - CNT_W'(1));

    // R7
    cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_remaining == '0 && !cnt_load) |=> cnt_remaining == '0);

    // R8
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> cnt_remaining == '0);

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R9
    discard_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discard_busy |=> !discard_busy);

    // R9
    discard_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discard_busy |=> (data_level == '0 && stat_level == '0 && !pkt_avail));
endmodule

bind rx_readout_fmt rx_readout_fmt_chk #(
    .CNT_W (CNT_W),
    .DLW   (DLW),
    .SLW   (SLW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_strobe     (rd_strobe),
    .rd_valid      (rd_valid),
    .discard_busy  (discard_busy),
    .data_level    (data_level),
    .stat_level    (stat_level),
    .pkt_avail     (pkt_avail),
    .irq           (irq),
    .irq_clr       (irq_clr),
    .cnt_load      (cnt_load),
    .cnt_remaining (cnt_remaining)
);

// File: tb/rx_readout_fmt_bench.sv
`timescale 1ns/1ps
module rx_readout_fmt_bench;
    localparam int LEN_W = 11;
    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_data_valid = 1'b0;
    logic [31:0]      wr_data = '0;
    logic             wr_len_valid = 1'b0;
    logic [LEN_W-1:0] wr_len = '0;
    logic [1:0]       cfg_end_align = '0;
    logic [4:0]       cfg_offset = '0;
    logic             cnt_load = 1'b0;
    logic [CNT_W-1:0] cnt_value = '0;
    logic             irq_clr = 1'b0;
    logic             discard_req = 1'b0;
    logic             rd_strobe = 1'b0;
    logic [31:0]      rd_data;
    logic             rd_valid, rd_last, pkt_avail, irq, discard_busy;
    logic [CNT_W-1:0] cnt_remaining;
    logic [4:0]       data_level;
    logic [2:0]       stat_level;

    int n_chk = 0;
    int n_bad = 0;
    int pid   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    rx_readout_fmt u_rx_readout_fmt (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int p, input int i);
        return 8'((p * 7 + i * 13 + 1) & 255);
    endfunction

    function automatic logic [31:0] exp_word(input int p, input int off, input int len, input int k);
        logic [31:0] w = '0;
        for (int j = 0; j < 4; j++) begin
            int s = 4 * k + j;
            if (s >= off && s - off < len) w[8*j +: 8] = pat(p, s - off);
        end
        return w;
    endfunction

    function automatic int exp_words(input int off, input int len, input int code);
        int n = (off + len + 3) / 4;
        int a = (code == 1) ? 4 : (code == 2) ? 8 : 1;
        return ((n + a - 1) / a) * a;
    endfunction

    task automatic push_word(input logic [31:0] w);
        @(negedge clk); wr_data_valid = 1'b1; wr_data = w;
        @(negedge clk); wr_data_valid = 1'b0;
    endtask

    task automatic push_len(input int len);
        @(negedge clk); wr_len_valid = 1'b1; wr_len = LEN_W'(len);
        @(negedge clk); wr_len_valid = 1'b0;
    endtask

    // Queue words carry 8'hA5 in lanes past the length (R5 masking).
    task automatic push_data(input int p, input int len);
        for (int k = 0; k < (len + 3) / 4; k++) begin
            logic [31:0] w = '0;
            for (int j = 0; j < 4; j++)
                w[8*j +: 8] = (4 * k + j < len) ? pat(p, 4 * k + j) : 8'hA5;
            push_word(w);
        end
    endtask

    task automatic read_word(output logic [31:0] d, output logic l, output logic v);
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        d = rd_data; l = rd_last; v = rd_valid;
    endtask

    task automatic run_pkt(input int off, input int code, input int len);
        logic [31:0] d; logic l, v;
        int n = exp_words(off, len, code);
        @(negedge clk); cfg_offset = 5'(off); cfg_end_align = 2'(code);
        push_data(pid, len);
        push_len(len);
        for (int k = 0; k < n; k++) begin
            read_word(d, l, v);
            chk("R1/R5 data", d, exp_word(pid, off, len, k));
            chk("R2 last", 32'(l), 32'(k == n - 1));
        end
        pid++;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d; logic l, v;
        int lens [8] = '{1, 2, 3, 4, 5, 7, 8, 13};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset valid", 32'(rd_valid), 0);
        chk("R8 reset irq", 32'(irq), 0);
        chk("R7 reset count", 32'(cnt_remaining), 0);
        chk("R9 reset levels", {data_level, stat_level, pkt_avail, discard_busy}, 0);

        // R6: strobe with nothing waiting is ignored
        read_word(d, l, v);
        chk("R6 idle strobe valid", 32'(v), 0);
        chk("R6 idle strobe levels", {data_level, stat_level, cnt_remaining}, 0);

        // R10: data alone does not announce a packet; the length entry does
        @(negedge clk); cfg_offset = 5'd0; cfg_end_align = 2'd0;
        push_data(pid, 6);
        chk("R10 no entry yet", 32'(pkt_avail), 0);
        push_len(6);
        chk("R10 entry waiting", 32'(pkt_avail), 1);
        for (int k = 0; k < 2; k++) begin
            read_word(d, l, v);
            chk("R10 data", d, exp_word(pid, 0, 6, k));
        end
        chk("R10 drained", 32'(pkt_avail), 0);
        pid++;

        // R1 R2 R5: sweep of every offset and alignment code over lengths
        for (int off = 0; off < 32; off++)
            for (int code = 0; code < 4; code++)
                for (int li = 0; li < 8; li++)
                    run_pkt(off, code, lens[li]);
        chk("R10 queues empty", {data_level, stat_level}, 0);

        // R3: alignment changed after the first read does not shorten the packet
        @(negedge clk); cfg_offset = 5'd0; cfg_end_align = 2'd2;
        push_data(pid, 4); push_len(4);
        for (int k = 0; k < 8; k++) begin
            read_word(d, l, v);
            if (k == 0) cfg_end_align = 2'd0;
            chk("R3 data", d, exp_word(pid, 0, 4, k));
            chk("R3 last", 32'(l), 32'(k == 7));
        end
        pid++;

        // R4: word offset lowered during leading words acts on the next read
        @(negedge clk); cfg_offset = 5'd12; cfg_end_align = 2'd0;
        push_data(pid, 4); push_len(4);
        read_word(d, l, v);
        chk("R4 lead word", d, 0);
        cfg_offset = 5'd4;
        read_word(d, l, v);
        chk("R4 word offset live", d, exp_word(pid, 0, 4, 0));
        chk("R4 word offset last", 32'(l), 1);
        pid++;

        // R4: byte offset held from packet start
        @(negedge clk); cfg_offset = 5'd1;
        push_data(pid, 8); push_len(8);
        for (int k = 0; k < 3; k++) begin
            read_word(d, l, v);
            if (k == 0) cfg_offset = 5'd2;
            chk("R4 byte offset held", d, exp_word(pid, 1, 8, k));
            chk("R4 byte offset last", 32'(l), 32'(k == 2));
        end
        pid++;

        // R7 R8: countdown with padding reads, reload, floor and clear
        @(negedge clk); cfg_offset = 5'd0; cfg_end_align = 2'd1;
        cnt_load = 1'b1; cnt_value = 12'd6;
        @(negedge clk); cnt_load = 1'b0;
        chk("R7 load", 32'(cnt_remaining), 6);
        push_data(pid, 8); push_len(8);
        for (int k = 0; k < 4; k++) read_word(d, l, v);
        chk("R7 counts padding", 32'(cnt_remaining), 2);
        chk("R8 not yet", 32'(irq), 0);
        pid++;
        @(negedge clk); cnt_load = 1'b1; cnt_value = 12'd3;
        @(negedge clk); cnt_load = 1'b0;
        chk("R7 reload replaces", 32'(cnt_remaining), 3);
        cfg_end_align = 2'd2;
        push_data(pid, 8); push_len(8);
        for (int k = 0; k < 2; k++) read_word(d, l, v);
        chk("R7 step", 32'(cnt_remaining), 1);
        chk("R8 before zero", 32'(irq), 0);
        read_word(d, l, v);
        chk("R7 zero", 32'(cnt_remaining), 0);
        chk("R8 set at zero", 32'(irq), 1);
        for (int k = 0; k < 5; k++) read_word(d, l, v);
        chk("R7 floor", 32'(cnt_remaining), 0);
        chk("R8 sticky", 32'(irq), 1);
        chk("R2 last of 8", 32'(l), 1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        chk("R8 cleared", 32'(irq), 0);
        pid++;

        // R9: discard while a packet is partly read
        @(negedge clk); cfg_end_align = 2'd0;
        push_data(pid, 12); push_len(12);
        read_word(d, l, v);
        push_word(32'h1111_2222); push_word(32'h3333_4444);
        @(negedge clk); discard_req = 1'b1;
        @(negedge clk); discard_req = 1'b0;
        chk("R9 busy", 32'(discard_busy), 1);
        @(negedge clk);
        chk("R9 self clear", 32'(discard_busy), 0);
        chk("R9 emptied", {data_level, stat_level, pkt_avail}, 0);
        pid++;
        run_pkt(3, 1, 5);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule